// File: doc/BRIEF.md
# UART Receive Character Buffer with Switchable Depth

This block is the receive-side character store of a memory-mapped UART, together with its status flags. Characters arrive from the serial receiver on a push port. They are read out in arrival order by a pop strobe, which comes from a read of the data register. The store is a circular array.

A line-control write port carries the buffering mode. When the enable bit of the line-control word is set, the store works as a 16-entry queue. When the bit is clear, it is a single holding register. Any write that flips the enable bit empties the store and returns every flag to its default value.

The outputs are:
- the oldest stored character, held in a register;
- a can-accept signal that tells the receiver whether another character fits;
- an 8-bit status word carrying the receive and transmit empty/full flags;
- the current line-control value.

Top module: `uart_rxq`

## Requirements
- R1: After synchronous reset, `status` is 0x90, `can_accept` is 1, `line_ctl` is 0 and the store is in single-entry mode.
- R2: Status bit positions are: receive-empty bit 4, transmit-full bit 5, receive-full bit 6, transmit-empty bit 7. Bits 3:0 read 0. With no transmit datapath, bit 7 stays 1 and bit 5 stays 0.
- R3: Queue mode is selected by bit 4 of the line-control word. In queue mode the store holds 16 characters, and receive-full is set by the push that makes the count 16.
- R4: Characters leave in arrival order, including across the wrap of the circular array. `head_data` shows the oldest stored character from the cycle after the edge that stored or popped it.
- R5: In single-entry mode one character makes the store full: receive-full is 1 and `can_accept` is 0.
- R6: A pop while the store is empty changes no state. `head_data` and `status` stay as they were.
- R7: Receive-empty is set by the pop that leaves the count at 0 and is cleared by every accepted push. Receive-empty and receive-full are never 1 together.
- R8: `can_accept` is 1 exactly when the count is below the depth of the current mode.
- R9: A push and a pop accepted in the same cycle leave the count unchanged. Receive-full is evaluated on the resulting count. A push and a pop in the same cycle on a full store drop the push and honour the pop.
- R10: A push presented while `can_accept` is 0 is dropped, and the stored contents do not change.
- R11: A line-control write that changes bit 4 empties the store and sets `status` to 0x90. A write that keeps bit 4 updates `line_ctl` only, and the stored characters survive.
- R12: A push or pop in the same cycle as a flushing line-control write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Receiver offers a character |
| push_data | input | DATA_W | Received character |
| pop | input | 1 | Data-register read strobe |
| lc_wr | input | 1 | Line-control write strobe |
| lc_wdata | input | LC_W | Line-control write value |
| head_data | output | DATA_W | Oldest stored character (registered) |
| can_accept | output | 1 | Store has room for a push |
| status | output | 8 | Empty/full flags at fixed bit positions |
| line_ctl | output | LC_W | Current line-control value |

## Verification
The scoreboard drives the store through these patterns:
- single-entry fill, overfill and drain, which separates the depth-1 full decision from the queue one;
- a 16-deep fill and drain, which shows where the full flag switches on;
- a partial fill followed by a refill across the array wrap, which exposes pointer-modulo mistakes;
- simultaneous push and pop at count 0, count 15 and count 16, which tell apart net-zero counting and the drop-on-full rule.

Line-control writes with and without a change of the enable bit, some carrying a push and a pop in the same cycle, separate a real flush from a plain register update.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  // status word bit positions
  localparam int unsigned ST_RX_EMPTY = 4;
  localparam int unsigned ST_TX_FULL  = 5;
  localparam int unsigned ST_RX_FULL  = 6;
  localparam int unsigned ST_TX_EMPTY = 7;
  localparam int unsigned ST_W        = 8;

  typedef struct packed {
    logic tx_empty;
    logic rx_full;
    logic tx_full;
    logic rx_empty;
  } rxq_flags_t;

  function automatic logic [ST_W-1:0] pack_status(rxq_flags_t f);
    logic [ST_W-1:0] s;
    s = '0;
    s[ST_RX_EMPTY] = f.rx_empty;
    s[ST_TX_FULL]  = f.tx_full;
    s[ST_RX_FULL]  = f.rx_full;
    s[ST_TX_EMPTY] = f.tx_empty;
    return s;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr_next,
  output logic [DATA_W-1:0] head_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // write port, no reset so the array can map to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read at the next head address with write-first bypass
  always_ff @(posedge clk) begin
    if (rst)
      head_q <= '0;
    else if (wr_en && (wr_addr == rd_addr_next))
      head_q <= wr_data;
    else
      head_q <= mem[rd_addr_next];
  end
endmodule

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          queue_mode,
  input  logic          push_valid,
  input  logic          pop,
  output logic          accept,
  output logic          pop_ok,
  output logic [AW-1:0] wr_slot,
  output logic [AW-1:0] rd_next,
  output logic [CW-1:0] cnt_next
);
  logic [AW-1:0] rd_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] mask;
  logic [CW-1:0] depth_cur;
  logic [AW-1:0] cnt_low;

  assign mask      = queue_mode ? AW'(DEPTH - 1) : '0;
  assign depth_cur = queue_mode ? CW'(DEPTH) : CW'(1);
  assign cnt_low   = cnt_q[AW-1:0];

  assign accept  = push_valid && !clear && (cnt_q < depth_cur);
  assign pop_ok  = pop && !clear && (cnt_q != '0);
  assign wr_slot = (rd_q + cnt_low) & mask;

  always_comb begin
    if (clear)
      rd_next = '0;
    else if (pop_ok)
      rd_next = (rd_q + AW'(1)) & mask;
    else
      rd_next = rd_q;
  end

  always_comb begin
    if (clear)
      cnt_next = '0;
    else
      cnt_next = cnt_q + CW'(accept) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_next;
      cnt_q <= cnt_next;
    end
  end

  // R3: count never exceeds the depth of the current mode
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= depth_cur);

  // R5: single-entry mode keeps its character in slot 0
  assert_single_slot_R5: assert property (@(posedge clk) disable iff (rst)
    !queue_mode |-> (rd_q == '0));

  // R6: pop on empty store with nothing else leaves pointers alone
  assert_pop_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && !push_valid && !clear && cnt_q == '0) |=> (cnt_q == '0) && $stable(rd_q));

  // R10: push refused on a full store with no pop keeps the count
  assert_drop_full_R10: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !pop && !clear && cnt_q == depth_cur) |=> $stable(cnt_q));

  // R9: simultaneous accepted push and pop is net zero
  assert_net_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && pop_ok) |=> $stable(cnt_q));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          queue_mode_next,
  input  logic          accept,
  input  logic          pop_ok,
  input  logic [CW-1:0] cnt_next,
  output rxq_flags_t    flags_q,
  output logic          can_accept_q
);
  logic          clear;
  logic [CW-1:0] depth_next;

  assign clear      = rst || flush;
  assign depth_next = queue_mode_next ? CW'(DEPTH) : CW'(1);

  always_ff @(posedge clk) begin
    if (clear) begin
      flags_q.rx_empty <= 1'b1;
      flags_q.rx_full  <= 1'b0;
      flags_q.tx_empty <= 1'b1;
      flags_q.tx_full  <= 1'b0;
      can_accept_q     <= 1'b1;
    end else begin
      if (accept)
        flags_q.rx_empty <= 1'b0;
      else if (pop_ok && cnt_next == '0)
        flags_q.rx_empty <= 1'b1;
      if (accept || pop_ok)
        flags_q.rx_full <= (cnt_next == depth_next);
      can_accept_q <= (cnt_next < depth_next);
    end
  end

  // R11: a flush restores all flag defaults
  assert_flush_defaults_R11: assert property (@(posedge clk) disable iff (rst)
    flush |=> (flags_q.rx_empty && !flags_q.rx_full && flags_q.tx_empty && !flags_q.tx_full && can_accept_q));

  // R7: empty and full are exclusive
  assert_empty_full_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(flags_q.rx_empty && flags_q.rx_full));

  // R8: a full store never advertises room
  assert_full_no_room_R8: assert property (@(posedge clk) disable iff (rst)
    flags_q.rx_full |-> !can_accept_q);

  // R7: an accepted push clears receive-empty
  assert_push_clears_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && !flush) |=> !flags_q.rx_empty);
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LC_W   = 8,
  parameter int unsigned EN_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              lc_wr,
  input  logic [LC_W-1:0]   lc_wdata,
  output logic [DATA_W-1:0] head_data,
  output logic              can_accept,
  output logic [7:0]        status,
  output logic [LC_W-1:0]   line_ctl
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [LC_W-1:0] lc_q;
  logic [LC_W-1:0] lc_next;
  logic            flush;
  logic            clear;
  logic            accept;
  logic            pop_ok;
  logic [AW-1:0]   wr_slot;
  logic [AW-1:0]   rd_next;
  logic [CW-1:0]   cnt_next;
  rxq_flags_t      flags_q;

  assign flush   = lc_wr && (lc_wdata[EN_BIT] != lc_q[EN_BIT]);
  assign clear   = rst || flush;
  assign lc_next = lc_wr ? lc_wdata : lc_q;

  always_ff @(posedge clk) begin
    if (rst) lc_q <= '0;
    else     lc_q <= lc_next;
  end

  rxq_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .queue_mode (lc_q[EN_BIT]),
    .push_valid (push_valid),
    .pop        (pop),
    .accept     (accept),
    .pop_ok     (pop_ok),
    .wr_slot    (wr_slot),
    .rd_next    (rd_next),
    .cnt_next   (cnt_next)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (accept),
    .wr_addr      (wr_slot),
    .wr_data      (push_data),
    .rd_addr_next (rd_next),
    .head_q       (head_data)
  );

  rxq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk             (clk),
    .rst             (rst),
    .flush           (flush),
    .queue_mode_next (lc_next[EN_BIT]),
    .accept          (accept),
    .pop_ok          (pop_ok),
    .cnt_next        (cnt_next),
    .flags_q         (flags_q),
    .can_accept_q    (can_accept)
  );

  assign status   = pack_status(flags_q);
  assign line_ctl = lc_q;

  // R12: nothing is stored in a flushing cycle
  assert_flush_no_store_R12: assert property (@(posedge clk) disable iff (rst)
    flush |=> flags_q.rx_empty);

  // R11: a write that keeps the enable bit does not flush
  assert_keep_no_flush_R11: assert property (@(posedge clk) disable iff (rst)
    (lc_wr && !flush && !pop && !flags_q.rx_empty) |=> !flags_q.rx_empty);
endmodule

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic       pop = 1'b0;
  logic       lc_wr = 1'b0;
  logic [7:0] lc_wdata = '0;
  logic [7:0] head_data;
  logic       can_accept;
  logic [7:0] status;
  logic [7:0] line_ctl;

  int checks = 0;
  int fails  = 0;
  logic [7:0] q[$];
  logic [7:0] m_lcr = '0;

  always #10 clk = ~clk;

  uart_rxq u_dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .pop(pop), .lc_wr(lc_wr), .lc_wdata(lc_wdata), .head_data(head_data),
    .can_accept(can_accept), .status(status), .line_ctl(line_ctl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mdepth();
    return m_lcr[4] ? 16 : 1;
  endfunction

  // scoreboard monitor: compares outputs with the queue model after each edge
  task automatic monitor_state();
    int d = mdepth();
    chk("R8 can_accept", 32'(can_accept), 32'(q.size() < d));
    chk("R7 rx_empty bit4", 32'(status[4]), 32'(q.size() == 0));
    chk("R3 rx_full bit6", 32'(status[6]), 32'(q.size() == d));
    chk("R2 tx/unused bits", {24'd0, status[7], status[5], 2'b0, status[3:0]}, 32'h80);
    chk("R11 line_ctl", 32'(line_ctl), 32'(m_lcr));
    if (q.size() > 0) chk("R4 head", 32'(head_data), 32'(q[0]));
  endtask

  // driver: one cycle of stimulus, model updated from the requirements
  task automatic cyc(input logic pv, input logic [7:0] pd, input logic pp,
                     input logic lw, input logic [7:0] ld);
    logic flush, acc, pok;
    flush = lw && (ld[4] != m_lcr[4]);
    pok   = pp && !flush && (q.size() > 0);
    acc   = pv && !flush && (q.size() < mdepth());
    if (pok) begin
      chk("R4 popped data", 32'(head_data), 32'(q[0]));
      void'(q.pop_front());
    end
    push_valid = pv; push_data = pd; pop = pp; lc_wr = lw; lc_wdata = ld;
    @(negedge clk);
    push_valid = 1'b0; pop = 1'b0; lc_wr = 1'b0;
    if (flush) q.delete();
    if (lw) m_lcr = ld;
    if (acc) q.push_back(pd);
    monitor_state();
  endtask

  task automatic push(input logic [7:0] d); cyc(1'b1, d, 1'b0, 1'b0, 8'h00); endtask
  task automatic popc(); cyc(1'b0, 8'h00, 1'b1, 1'b0, 8'h00); endtask
  task automatic lcw(input logic [7:0] v); cyc(1'b0, 8'h00, 1'b0, 1'b1, v); endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] h;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", 32'(status), 32'h90);
    chk("R1 reset can_accept", 32'(can_accept), 32'd1);
    chk("R1 reset line_ctl", 32'(line_ctl), 32'd0);
    monitor_state();

    // single-entry mode
    push(8'hA5);
    chk("R5 one char fills", 32'(status), 32'hC0);
    push(8'h3C);
    chk("R10 dropped push", 32'(head_data), 32'hA5);
    popc();
    chk("R7 empty after pop", 32'(status), 32'h90);
    h = head_data;
    popc();
    chk("R6 head held", 32'(head_data), 32'(h));
    chk("R6 status held", 32'(status), 32'h90);
    cyc(1'b1, 8'h5A, 1'b1, 1'b0, 8'h00);
    chk("R9 pop on empty with push", 32'(status), 32'hC0);
    cyc(1'b1, 8'h99, 1'b1, 1'b0, 8'h00);
    chk("R9 full push dropped pop honoured", 32'(status), 32'h90);
    push(8'h11);
    lcw(8'h01);
    chk("R11 keep bit4 no flush", 32'(head_data), 32'h11);

    // queue mode
    lcw(8'h11);
    chk("R11 flush status", 32'(status), 32'h90);
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
    chk("R3 full at 16", 32'(status), 32'hC0);
    push(8'hFF);
    chk("R10 dropped in queue mode", 32'(status), 32'hC0);
    for (int i = 0; i < 16; i++) popc();
    chk("R7 drained", 32'(status), 32'h90);

    // wrap
    for (int i = 0; i < 10; i++) push(8'h60 + 8'(i));
    for (int i = 0; i < 6; i++) popc();
    for (int i = 0; i < 12; i++) push(8'h80 + 8'(i));
    chk("R4 wrap full", 32'(status), 32'hC0);
    for (int i = 0; i < 16; i++) popc();

    // simultaneous push and pop
    for (int i = 0; i < 15; i++) push(8'hB0 + 8'(i));
    cyc(1'b1, 8'hC1, 1'b1, 1'b0, 8'h00);
    chk("R9 net zero not full", 32'(status[6]), 32'd0);
    push(8'hC2);
    cyc(1'b1, 8'hC3, 1'b1, 1'b0, 8'h00);
    chk("R9 full pair", 32'(can_accept), 32'd1);

    // write keeping bit4, then flush with push and pop in same cycle
    lcw(8'h13);
    chk("R11 contents kept", 32'(status), 32'h80);
    cyc(1'b1, 8'hEE, 1'b1, 1'b1, 8'h03);
    chk("R12 flush discards push", 32'(status), 32'h90);
    push(8'h77);
    chk("R12 single mode after flush", 32'(head_data), 32'h77);
    popc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule